// File: doc/BRIEF.md
# Accumulator Special-Function Unit

This unit post-processes a pair of 36-bit signed accumulators under a 4-bit secondary function code. Each accepted operation reads one accumulator (the source), computes a result (a fixed arithmetic shift, a product or y load, a plain or high-half increment, a rounding, a copy or a negation) and writes it into one accumulator (the destination) on the next rising clock edge. The four status flags are updated on that same edge.

The surrounding datapath supplies the already-aligned product value, the y register and one keep-low control bit per accumulator. Code 10 has no operation. It leaves all state untouched and raises a one-cycle illegal-operation pulse. A sequencer drives one operation per cycle with `opValid` and reads the accumulators and flags directly.

Top module: `acc_sfu_top`

## Requirements
- R1: After reset both accumulators read zero, `flags` reads 4'b0000 and `illegalOp` is low.
- R2: Codes 0, 2, 4 and 6 write the source shifted arithmetically right by 1, 4, 8 and 16 bits.
- R3: Codes 1, 3, 5 and 7 shift the source left by 1, 4, 8 and 16 bits. The result keeps only the low 32 bits, sign-extended from bit 31 to 36 bits, so both overflow flags read 0.
- R4: Code 8 writes the 36-bit `product` input. Code 12 writes `yVal` sign-extended from bit 31.
- R5: Code 13 writes source+1, code 14 writes the source unchanged and code 15 writes the two's-complement negation of the source.
- R6: Code 9 clears the low 16 bits of the source and adds 1 at bit 16. When `keepLow[i]` is 1, with i the source select, the low 16 bits of the result are the destination's previous low 16 bits. Otherwise they are zero.
- R7: Code 11 adds 2^15 to a non-negative source, or subtracts 2^15 from a negative source, then clears the low 16 bits.
- R8: `flags` is {N, Z, V36, V32}, bit 3 down to bit 0. N is result bit 35. Z is set when the 36-bit result is zero. V36 is set when the exact result does not fit in 36 signed bits. V32 is set when result bits 35..32 differ from copies of bit 31.
- R9: Code 10 changes neither accumulator nor the flags. `illegalOp` is high for exactly the one cycle that follows it.
- R10: With `opValid` low, the accumulators, flags and `illegalOp` do not change.
- R11: Only the destination accumulator is written. The other one keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Accept the operation this cycle |
| funcCode | input | 4 | Secondary function code |
| srcSel | input | 1 | Source accumulator index |
| dstSel | input | 1 | Destination accumulator index |
| product | input | 36 | Aligned product value |
| yVal | input | 32 | y register value |
| keepLow | input | 2 | Per-accumulator keep-low control for code 9 |
| acc0 | output | 36 | Accumulator 0 |
| acc1 | output | 36 | Accumulator 1 |
| flags | output | 4 | {N, Z, V36, V32} |
| illegalOp | output | 1 | One-cycle pulse after the reserved code |

## Verification
The table drives every shift amount in both directions with positive, negative and guard-bit-laden sources. These cases separate an arithmetic right shift from a logical one, and a 32-bit truncation from a 36-bit left shift. Increment and negation are tried at the largest positive value and the most negative value, where only an exact-width model sets both overflow flags. The rounding and high-half cases use sources just below and across the 2^15 boundary and run with keep-low both clear and set, which shows which operand the kept low half comes from. Directed steps cover the y sign extension, the reserved code, the idle cycles and the accumulator that is not written.

// File: rtl/acc_sfu_pkg.sv
package acc_sfu_pkg;
  localparam int ACC_W   = 36;
  localparam int Y_W     = 32;
  localparam int HALF_W  = 16;
  localparam int NUM_ACC = 2;
  localparam int SEL_W   = $clog2(NUM_ACC);
  localparam int WIDE_W  = ACC_W + 2;
  localparam int AMT_W   = 5;
  localparam int FLAG_W  = 4;

  localparam logic [3:0] CODE_PROD = 4'd8;
  localparam logic [3:0] CODE_HINC = 4'd9;
  localparam logic [3:0] CODE_RSV  = 4'd10;
  localparam logic [3:0] CODE_RND  = 4'd11;
  localparam logic [3:0] CODE_Y    = 4'd12;
  localparam logic [3:0] CODE_INC  = 4'd13;
  localparam logic [3:0] CODE_CPY  = 4'd14;
  localparam logic [3:0] CODE_NEG  = 4'd15;

  typedef enum logic [3:0] {
    OP_SHR, OP_SHL, OP_PROD, OP_HINC, OP_RND, OP_Y, OP_INC, OP_CPY, OP_NEG, OP_NONE
  } opKind_t;

  typedef struct packed {
    logic             wrEn;
    opKind_t          opKind;
    logic [AMT_W-1:0] shiftAmt;
  } strobes_t;
endpackage

// File: rtl/acc_sfu_ctrl.sv
module acc_sfu_ctrl
  import acc_sfu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] funcCode,
  output strobes_t   stb,
  output logic       illegalQ
);
  logic isRsv;
  logic [AMT_W-1:0] amt;

  always_comb begin
    case (funcCode[2:1])
      2'd0:    amt = AMT_W'(1);
      2'd1:    amt = AMT_W'(4);
      2'd2:    amt = AMT_W'(8);
      default: amt = AMT_W'(16);
    endcase
  end

  always_comb begin
    stb.shiftAmt = amt;
    stb.opKind   = OP_NONE;
    if (!funcCode[3]) begin
      stb.opKind = funcCode[0] ? OP_SHL : OP_SHR;
    end else begin
      case (funcCode)
        CODE_PROD: stb.opKind = OP_PROD;
        CODE_HINC: stb.opKind = OP_HINC;
        CODE_RND:  stb.opKind = OP_RND;
        CODE_Y:    stb.opKind = OP_Y;
        CODE_INC:  stb.opKind = OP_INC;
        CODE_CPY:  stb.opKind = OP_CPY;
        CODE_NEG:  stb.opKind = OP_NEG;
        default:   stb.opKind = OP_NONE;
      endcase
    end
    isRsv    = opValid && (funcCode == CODE_RSV);
    stb.wrEn = opValid && (stb.opKind != OP_NONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalQ <= 1'b0;
    else       illegalQ <= isRsv;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    illegalQ |=> (!illegalQ || $past(opValid && funcCode == CODE_RSV))); // R9
endmodule

// File: rtl/acc_sfu_dp.sv
module acc_sfu_dp
  import acc_sfu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic [ACC_W-1:0]  product,
  input  logic [Y_W-1:0]    yVal,
  input  logic [NUM_ACC-1:0] keepLow,
  output logic [ACC_W-1:0]  accOut [NUM_ACC],
  output logic [FLAG_W-1:0] flagOut
);
  logic [ACC_W-1:0]  accQ [NUM_ACC];
  logic [FLAG_W-1:0] flagQ;
  logic signed [WIDE_W-1:0] srcW, res, rndStep, hincBase;
  logic [ACC_W-1:0] srcAcc, dstAcc;
  logic [Y_W-1:0]   shlLow;
  logic [FLAG_W-1:0] flagNext;

  assign srcAcc = accQ[srcSel];
  assign dstAcc = accQ[dstSel];
  assign srcW   = WIDE_W'($signed(srcAcc));
  assign shlLow = srcAcc[Y_W-1:0] << stb.shiftAmt;
  assign rndStep  = srcAcc[ACC_W-1] ? -(WIDE_W'(1) <<< (HALF_W-1)) : (WIDE_W'(1) <<< (HALF_W-1));
  assign hincBase = {srcW[WIDE_W-1:HALF_W], {HALF_W{1'b0}}} + (WIDE_W'(1) <<< HALF_W);

  always_comb begin
    res = srcW;
    case (stb.opKind)
      OP_SHR:  res = srcW >>> stb.shiftAmt;
      OP_SHL:  res = WIDE_W'($signed(shlLow));
      OP_PROD: res = WIDE_W'($signed(product));
      OP_Y:    res = WIDE_W'($signed(yVal));
      OP_INC:  res = srcW + WIDE_W'(1);
      OP_CPY:  res = srcW;
      OP_NEG:  res = -srcW;
      OP_RND: begin
        res = srcW + rndStep;
        res[HALF_W-1:0] = '0;
      end
      OP_HINC: begin
        res = hincBase;
        if (keepLow[srcSel]) res[HALF_W-1:0] = dstAcc[HALF_W-1:0];
      end
      default: res = srcW;
    endcase
  end

  always_comb begin
    flagNext[3] = res[ACC_W-1];
    flagNext[2] = (res[ACC_W-1:0] == '0);
    flagNext[1] = (res[WIDE_W-1:ACC_W] != {(WIDE_W-ACC_W){res[ACC_W-1]}});
    flagNext[0] = (res[ACC_W-1:Y_W] != {(ACC_W-Y_W){res[Y_W-1]}});
  end

  for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accQ[gi] <= '0;
      else if (stb.wrEn && dstSel == SEL_W'(gi)) accQ[gi] <= res[ACC_W-1:0];
    end
    assign accOut[gi] = accQ[gi];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flagQ <= '0;
    else if (stb.wrEn) flagQ <= flagNext;
  end
  assign flagOut = flagQ;

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> flagQ[2] == (accQ[$past(dstSel)] == '0)); // R8
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> flagQ[3] == accQ[$past(dstSel)][ACC_W-1]); // R8
  AST_SHL_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.opKind == OP_SHL) |=> (!flagQ[1] && !flagQ[0])); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> ($stable(accQ[0]) && $stable(accQ[1]) && $stable(flagQ))); // R10
endmodule

// File: rtl/acc_sfu_top.sv
module acc_sfu_top
  import acc_sfu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [3:0]  funcCode,
  input  logic        srcSel,
  input  logic        dstSel,
  input  logic [35:0] product,
  input  logic [31:0] yVal,
  input  logic [1:0]  keepLow,
  output logic [35:0] acc0,
  output logic [35:0] acc1,
  output logic [3:0]  flags,
  output logic        illegalOp
);
  strobes_t stb;
  logic [ACC_W-1:0] accArr [NUM_ACC];

  acc_sfu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .funcCode(funcCode),
    .stb(stb), .illegalQ(illegalOp)
  );

  acc_sfu_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcSel(srcSel), .dstSel(dstSel),
    .product(product), .yVal(yVal), .keepLow(keepLow),
    .accOut(accArr), .flagOut(flags)
  );

  assign acc0 = accArr[0];
  assign acc1 = accArr[1];

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> ($stable(acc0) && $stable(acc1) && $stable(flags))); // R9
endmodule

// File: tb/sim_acc_sfu_top.sv
`timescale 1ns/100ps
module sim_acc_sfu_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] funcCode = '0;
  logic srcSel = 1'b0, dstSel = 1'b0;
  logic [35:0] product = '0;
  logic [31:0] yVal = '0;
  logic [1:0] keepLow = '0;
  logic [35:0] acc0, acc1;
  logic [3:0] flags;
  logic illegalOp;
  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acc_sfu_top u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .funcCode(funcCode),
    .srcSel(srcSel), .dstSel(dstSel), .product(product), .yVal(yVal),
    .keepLow(keepLow), .acc0(acc0), .acc1(acc1), .flags(flags), .illegalOp(illegalOp)
  );

  // func, seed, keepLow, expected acc1, expected flags {N,Z,V36,V32}
  localparam int NV = 18;
  localparam logic [81:0] VEC [NV] = '{
    {4'd0,  36'h800000010, 2'b00, 36'hC00000008, 4'b1001}, // R2
    {4'd2,  36'h012345670, 2'b00, 36'h001234567, 4'b0000}, // R2
    {4'd4,  36'hFFFFFFF00, 2'b00, 36'hFFFFFFFFF, 4'b1000}, // R2
    {4'd6,  36'h700000000, 2'b00, 36'h000070000, 4'b0000}, // R2
    {4'd1,  36'h040000001, 2'b00, 36'hF80000002, 4'b1000}, // R3
    {4'd3,  36'hA12345678, 2'b00, 36'h023456780, 4'b0000}, // R3
    {4'd5,  36'h000FF0000, 2'b00, 36'hFFF000000, 4'b1000}, // R3
    {4'd7,  36'h000010000, 2'b00, 36'h000000000, 4'b0100}, // R3
    {4'd13, 36'h7FFFFFFFF, 2'b00, 36'h800000000, 4'b1011}, // R5
    {4'd14, 36'h300001234, 2'b00, 36'h300001234, 4'b0001}, // R5
    {4'd15, 36'h800000000, 2'b00, 36'h800000000, 4'b1011}, // R5
    {4'd15, 36'h000000005, 2'b00, 36'hFFFFFFFFB, 4'b1000}, // R5
    {4'd11, 36'h012348000, 2'b00, 36'h012350000, 4'b0000}, // R7
    {4'd11, 36'hFFFFF7FFF, 2'b00, 36'hFFFFE0000, 4'b1000}, // R7
    {4'd11, 36'h000007FFF, 2'b00, 36'h000000000, 4'b0100}, // R7
    {4'd9,  36'h012345678, 2'b00, 36'h012350000, 4'b0000}, // R6
    {4'd9,  36'h012345678, 2'b01, 36'h01235ABCD, 4'b0000}, // R6
    {4'd9,  36'hFFFFF1234, 2'b00, 36'h000000000, 4'b0100}  // R6
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] f, input logic s, input logic d,
                      input logic [35:0] p, input logic [31:0] y, input logic [1:0] k);
    @(negedge clk);
    funcCode = f; srcSel = s; dstSel = d; product = p; yVal = y; keepLow = k;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    logic [35:0] a0s, a1s;
    logic [3:0] fs;
    repeat (3) @(negedge clk);
    check("R1 acc0", acc0, '0);
    check("R1 acc1", acc1, '0);
    check("R1 flags", 36'(flags), '0);
    check("R1 illegal", 36'(illegalOp), '0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VEC[i];
      doOp(4'd8, 1'b0, 1'b0, v[77:42], '0, 2'b00);
      doOp(4'd8, 1'b0, 1'b1, 36'h00000ABCD, '0, 2'b00);
      doOp(v[81:78], 1'b0, 1'b1, '0, '0, v[41:40]);
      check($sformatf("R%0s vec%0d acc", (v[81:78] < 4'd8) ? (v[78] ? "3" : "2") :
            (v[81:78] == 4'd9) ? "6" : (v[81:78] == 4'd11) ? "7" : "5", i), acc1, v[39:4]);
      check($sformatf("R8 vec%0d flags", i), 36'(flags), 36'(v[3:0]));
    end

    // R4: product load and y sign extension
    doOp(4'd8, 1'b1, 1'b0, 36'h800000000, '0, 2'b00);
    check("R4 product", acc0, 36'h800000000);
    check("R8 product flags", 36'(flags), 36'(4'b1001));
    doOp(4'd12, 1'b0, 1'b1, '0, 32'h80000000, 2'b00);
    check("R4 y load", acc1, 36'hF80000000);
    check("R8 y flags", 36'(flags), 36'(4'b1000));
    check("R11 other acc kept", acc0, 36'h800000000);

    // R11: copy acc1 into acc0, acc1 untouched
    doOp(4'd14, 1'b1, 1'b0, '0, '0, 2'b00);
    check("R11 copy dst", acc0, 36'hF80000000);
    check("R11 copy src kept", acc1, 36'hF80000000);

    // R9: reserved code
    doOp(4'd8, 1'b0, 1'b0, 36'h012345678, '0, 2'b00);
    a0s = acc0; a1s = acc1; fs = flags;
    doOp(4'd10, 1'b0, 1'b1, 36'h0FFFFFFFF, 32'h1, 2'b11);
    check("R9 illegal pulse", 36'(illegalOp), 36'd1);
    check("R9 acc0 kept", acc0, a0s);
    check("R9 acc1 kept", acc1, a1s);
    check("R9 flags kept", 36'(flags), 36'(fs));
    @(negedge clk);
    check("R9 pulse one cycle", 36'(illegalOp), 36'd0);

    // R10: idle with an operation on the inputs
    @(negedge clk);
    funcCode = 4'd15; srcSel = 1'b0; dstSel = 1'b1; product = 36'h111111111;
    repeat (3) @(negedge clk);
    check("R10 acc0 idle", acc0, a0s);
    check("R10 acc1 idle", acc1, a1s);
    check("R10 flags idle", 36'(flags), 36'(fs));
    check("R10 illegal idle", 36'(illegalOp), 36'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule